// File: doc/BRIEF.md
# Programmable-Priority Interrupt Unit

This block gathers interrupt requests and hands one at a time to the processor core as an 8-bit vector. There are three kinds of source:

- an 8-bit external port, asynchronous and active low;
- four internal requests from a DMA engine;
- a non-maskable input, also active low.

The external port has two modes. In encoded mode the port carries a vector value directly, so an outside encoder can name up to 248 sources. In dedicated mode each of the eight pins is its own source. Each dedicated pin has a programmable vector and can be set to level or edge sensitivity.

A source's priority is the upper five bits of its vector. A source is offered to the core only when that priority is strictly greater than the priority the core is running at. The non-maskable source is the exception: it beats every other source and ignores the running priority. Among sources of equal priority, the lowest source index wins.

The core is told through a request/acknowledge handshake. A request, once raised, holds its vector until the core acknowledges it. An acknowledge also clears the latched pending state of an edge-type source.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset, `irq_req_o` is 0 and `irq_vec_o` is 0.
- R2: External pins pass through a two-stage synchroniser. A dedicated level pin driven low just before rising edge e raises `irq_req_o` after edge e+2. A DMA request raises it after the next edge. Both latencies assume the request path is free and the source qualifies.
- R3: In encoded mode (`port_dedicated_i`=0), the candidate vector is the bitwise inverse of the synchronised pin levels. This makes the all-high idle state read as vector 0.
- R4: In dedicated mode (`port_dedicated_i`=1), pin i uses vector `line_vec_i[8i+7:8i]`. With `line_edge_i[i]`=0 the pin requests while it is low. With `line_edge_i[i]`=1 a high-to-low transition latches a pending bit. That bit stays set after the pin returns high and is cleared only when the core acknowledges that pin's request. A new edge in the acknowledge cycle sets the bit again.
- R5: The priority of a vector is its bits [7:3]. An ordinary source is offered only if this value is strictly greater than `cur_prio_i`. A source at equal or lower priority waits without being lost.
- R6: At equal priority the lowest source index wins. Indices 0 to 7 are the port pins, with the encoded source counted as index 0. Indices 8 to 11 are DMA requests 0 to 3. Among different priorities, the highest wins.
- R7: A falling edge on `nmi_ni` latches a pending bit. The next free request slot goes to it with vector 248, ahead of every other source and regardless of `cur_prio_i`. Its acknowledge clears the bit.
- R8: While `irq_req_o` is 1 and `irq_ack_i` is 0, the request and its vector stay unchanged. This holds even if a better source appears. An edge with both high drops `irq_req_o`, and the next request can be raised one edge later at the earliest.
- R9: Vectors 0 to 7 are reserved and never delivered, whatever their source.
- R10: DMA requests are active-high levels taken without synchronisation. DMA request j uses vector `dma_vec_i[8j+7:8j]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ext_pin_ni | input | 8 | External interrupt port, asynchronous, active low |
| nmi_ni | input | 1 | Non-maskable request, asynchronous, falling-edge |
| port_dedicated_i | input | 1 | 1: pins are individual sources; 0: pins carry an encoded vector |
| line_edge_i | input | 8 | Per-pin sensitivity in dedicated mode: 1 edge, 0 level |
| line_vec_i | input | 64 | Vector of each dedicated pin, pin i at bits 8i+7:8i |
| dma_req_i | input | 4 | DMA interrupt requests, active high |
| dma_vec_i | input | 32 | Vector of each DMA request, request j at bits 8j+7:8j |
| cur_prio_i | input | 5 | Running processor priority |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 8 | Vector of the current request |
| irq_ack_i | input | 1 | Core acknowledges the current request |

## Verification
The hardest situation to reach is the non-maskable source competing with ordinary pending sources for one free slot.

The non-maskable path takes three edges to latch, while a DMA request reaches the arbiter after one. Without help, the DMA request always wins the race. The stimulus therefore withholds the acknowledge to park an unrelated request. It then raises a DMA request and pulses the non-maskable input behind it. When the acknowledge is finally given, both candidates are already waiting for the same free slot.

Edge-latched pins are handled the same way. They are first pulsed under a high running priority, so that they have to survive as pending state until the priority is lowered.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int VEC_W  = 8;
    localparam int PRIO_W = 5;

    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [PRIO_W-1:0] prio_t;

    function automatic prio_t prio_of(input vec_t v);
        return v[VEC_W-1 -: PRIO_W];
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] level_ni,
    input  logic [N-1:0] edge_en_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } cap_st_t;

    cap_st_t      st_d, st_q;
    logic [N-1:0] fall;

    always_comb begin
        fall       = st_q.prev & ~level_ni;
        st_d.prev  = level_ni;
        st_d.pend  = ((st_q.pend & ~clr_i) | fall) & edge_en_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.prev <= '1;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N        = 12,
    parameter int RSVD_MAX = 7,
    parameter int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][VEC_W-1:0] vec_i,
    input  prio_t                   floor_i,
    output logic                    found_o,
    output logic [IDX_W-1:0]        idx_o,
    output vec_t                    vec_o
);
    logic qual;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        vec_o   = '0;
        qual    = 1'b0;
        for (int i = 0; i < N; i++) begin
            qual = valid_i[i]
                && (vec_i[i] > vec_t'(RSVD_MAX))
                && (prio_of(vec_i[i]) > floor_i);
            if (qual && (!found_o || prio_of(vec_i[i]) > prio_of(vec_o))) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                vec_o   = vec_i[i];
            end
        end
    end
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
    import irq_pkg::*;
#(
    parameter int N_DMA    = 4,
    parameter int RSVD_MAX = 7,
    parameter int NMI_VEC  = 248
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [VEC_W-1:0]       ext_pin_ni,
    input  logic                   nmi_ni,
    input  logic                   port_dedicated_i,
    input  logic [VEC_W-1:0]       line_edge_i,
    input  logic [VEC_W*VEC_W-1:0] line_vec_i,
    input  logic [N_DMA-1:0]       dma_req_i,
    input  logic [N_DMA*VEC_W-1:0] dma_vec_i,
    input  logic [PRIO_W-1:0]      cur_prio_i,
    output logic                   irq_req_o,
    output logic [VEC_W-1:0]       irq_vec_o,
    input  logic                   irq_ack_i
);
    localparam int N_LINES = VEC_W;
    localparam int N_SRC   = N_LINES + N_DMA;
    localparam int IDX_W   = $clog2(N_SRC);

    typedef struct packed {
        logic             req;
        logic             nmi;
        logic [IDX_W-1:0] src;
        vec_t             vec;
    } hs_st_t;

    hs_st_t st_d, st_q;

    logic [N_LINES-1:0]            ext_sync;
    logic                          nmi_sync;
    logic [N_LINES-1:0]            line_pend;
    logic [N_LINES-1:0]            line_clr;
    logic [N_LINES-1:0]            edge_en;
    logic                          nmi_pend;
    logic                          nmi_clr;
    logic [N_SRC-1:0]              cand_valid;
    logic [N_SRC-1:0][VEC_W-1:0]   cand_vec;
    logic                          win_found;
    logic [IDX_W-1:0]              win_idx;
    vec_t                          win_vec;
    logic                          grant_nmi;

    irq_sync #(.W(N_LINES), .RST_VAL('1)) u_ext_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ext_pin_ni),
        .sync_o  (ext_sync)
    );

    irq_sync #(.W(1), .RST_VAL(1'b1)) u_nmi_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (nmi_ni),
        .sync_o  (nmi_sync)
    );

    assign edge_en = line_edge_i & {N_LINES{port_dedicated_i}};

    irq_capture #(.N(N_LINES)) u_line_cap (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .level_ni  (ext_sync),
        .edge_en_i (edge_en),
        .clr_i     (line_clr),
        .pend_o    (line_pend)
    );

    irq_capture #(.N(1)) u_nmi_cap (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .level_ni  (nmi_sync),
        .edge_en_i (1'b1),
        .clr_i     (nmi_clr),
        .pend_o    (nmi_pend)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        if (i == 0) begin : g_enc
            assign cand_valid[i] = port_dedicated_i
                                 ? (line_edge_i[i] ? line_pend[i] : ~ext_sync[i])
                                 : 1'b1;
            assign cand_vec[i]   = port_dedicated_i
                                 ? line_vec_i[i*VEC_W +: VEC_W]
                                 : ~ext_sync;
        end else begin : g_ded
            assign cand_valid[i] = port_dedicated_i
                                 & (line_edge_i[i] ? line_pend[i] : ~ext_sync[i]);
            assign cand_vec[i]   = line_vec_i[i*VEC_W +: VEC_W];
        end
    end

    for (genvar j = 0; j < N_DMA; j++) begin : g_dma
        assign cand_valid[N_LINES+j] = dma_req_i[j];
        assign cand_vec[N_LINES+j]   = dma_vec_i[j*VEC_W +: VEC_W];
    end

    irq_arbiter #(.N(N_SRC), .RSVD_MAX(RSVD_MAX), .IDX_W(IDX_W)) u_arb (
        .valid_i (cand_valid),
        .vec_i   (cand_vec),
        .floor_i (cur_prio_i),
        .found_o (win_found),
        .idx_o   (win_idx),
        .vec_o   (win_vec)
    );

    always_comb begin
        st_d     = st_q;
        line_clr = '0;
        nmi_clr  = 1'b0;
        if (st_q.req && irq_ack_i) begin
            st_d.req = 1'b0;
            if (st_q.nmi) begin
                nmi_clr = 1'b1;
            end else begin
                for (int k = 0; k < N_LINES; k++) begin
                    if (st_q.src == IDX_W'(k)) line_clr[k] = 1'b1;
                end
            end
        end else if (!st_q.req) begin
            if (nmi_pend) begin
                st_d.req = 1'b1;
                st_d.nmi = 1'b1;
                st_d.src = '0;
                st_d.vec = vec_t'(NMI_VEC);
            end else if (win_found) begin
                st_d.req = 1'b1;
                st_d.nmi = 1'b0;
                st_d.src = win_idx;
                st_d.vec = win_vec;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_req_o = st_q.req;
    assign irq_vec_o = st_q.vec;
    assign grant_nmi = st_q.nmi;
endmodule

// File: rtl/irq_prio_unit_chk.sv
module irq_prio_unit_chk
    import irq_pkg::*;
#(
    parameter int RSVD_MAX = 7,
    parameter int NMI_VEC  = 248
) (
    input logic  clk_i,
    input logic  rst_ni,
    input logic  req_i,
    input vec_t  vec_i,
    input logic  ack_i,
    input prio_t prio_i,
    input logic  nmi_pend_i,
    input logic  nmi_grant_i
);
    // R8
    hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i && !ack_i |=> req_i && $stable(vec_i));

    // R8
    drop_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i && ack_i |=> !req_i);

    // R9
    no_reserved_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |-> vec_i > vec_t'(RSVD_MAX));

    // R5
    outranks_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_i) && !nmi_grant_i |-> prio_of(vec_i) > $past(prio_i));

    // R7
    nmi_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_pend_i && !req_i |=> req_i && nmi_grant_i && vec_i == vec_t'(NMI_VEC));
endmodule

bind irq_prio_unit irq_prio_unit_chk #(
    .RSVD_MAX (RSVD_MAX),
    .NMI_VEC  (NMI_VEC)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (irq_req_o),
    .vec_i       (irq_vec_o),
    .ack_i       (irq_ack_i),
    .prio_i      (cur_prio_i),
    .nmi_pend_i  (nmi_pend),
    .nmi_grant_i (grant_nmi)
);

// File: tb/test_irq_prio_unit.sv
module test_irq_prio_unit;
    localparam int NMI_V = 248;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = 8'hFF;
    logic        nmi_n = 1'b1;
    logic        ded = 1'b0;
    logic [7:0]  edge_cfg = 8'h00;
    logic [63:0] lvec = '0;
    logic [3:0]  dma = 4'h0;
    logic [31:0] dvec = {8'h42, 8'h50, 8'h41, 8'h40};
    logic [4:0]  cprio = 5'd0;
    logic        ack = 1'b0;
    logic        req;
    logic [7:0]  vec;

    int    checks = 0;
    int    errors = 0;
    string phase = "R1";
    bit    auto_ack = 1'b1;
    bit    svc = 1'b0;
    logic [7:0] got[$];

    always #4 clk = ~clk;

    irq_prio_unit i_irq_prio_unit (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .ext_pin_ni       (pins),
        .nmi_ni           (nmi_n),
        .port_dedicated_i (ded),
        .line_edge_i      (edge_cfg),
        .line_vec_i       (lvec),
        .dma_req_i        (dma),
        .dma_vec_i        (dvec),
        .cur_prio_i       (cprio),
        .irq_req_o        (req),
        .irq_vec_o        (vec),
        .irq_ack_i        (ack)
    );

    // Behavioural reference: pin history queue, pending sets, one held request.
    logic [7:0] hist[$];
    logic       nhist[$];
    logic [7:0] m_pend;
    logic       m_np;
    logic       m_req;
    logic [7:0] m_vec;
    int         m_src;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{8'hFF, 8'hFF, 8'hFF};
            nhist = '{1'b1, 1'b1, 1'b1};
            m_pend = '0; m_np = 1'b0; m_req = 1'b0; m_vec = '0; m_src = 0;
        end else begin
            logic [7:0] view, prev, npend;
            logic       nnp;
            int         best;
            logic [7:0] bvec;
            view = hist[1]; prev = hist[2];
            npend = m_pend; nnp = m_np;
            if (m_req && ack) begin
                m_req = 1'b0;
                if (m_src < 0) nnp = 1'b0;
                else if (m_src < 8) npend[m_src] = 1'b0;
            end else if (!m_req) begin
                if (m_np) begin
                    m_req = 1'b1; m_vec = 8'(NMI_V); m_src = -1;
                end else begin
                    best = -1; bvec = '0;
                    for (int i = 0; i < 12; i++) begin
                        logic       v;
                        logic [7:0] cv;
                        if (i < 8) begin
                            if (ded) begin
                                v = edge_cfg[i] ? m_pend[i] : !view[i];
                                cv = lvec[i*8 +: 8];
                            end else begin
                                v = (i == 0); cv = ~view;
                            end
                        end else begin
                            v = dma[i-8]; cv = dvec[(i-8)*8 +: 8];
                        end
                        if (v && cv > 8'd7 && cv[7:3] > cprio
                            && (best < 0 || cv[7:3] > bvec[7:3])) begin
                            best = i; bvec = cv;
                        end
                    end
                    if (best >= 0) begin
                        m_req = 1'b1; m_vec = bvec; m_src = best;
                    end
                end
            end
            m_pend = (npend | (prev & ~view)) & edge_cfg & {8{ded}};
            m_np = nnp | (nhist[2] & ~nhist[1]);
            void'(hist.pop_back()); hist.push_front(pins);
            void'(nhist.pop_back()); nhist.push_front(nmi_n);
        end
    end

    task automatic service(input logic [7:0] v);
        for (int j = 0; j < 4; j++) if (dvec[j*8 +: 8] == v) dma[j] = 1'b0;
        if (ded) begin
            for (int i = 0; i < 8; i++) if (lvec[i*8 +: 8] == v) pins[i] = 1'b1;
        end else if (v != 8'(NMI_V)) begin
            pins = 8'hFF;
        end
    endtask

    // Per-cycle comparison, then the core-side acknowledge behaviour.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (req !== m_req || (m_req && vec !== m_vec)) begin
                errors++;
                $display("FAIL %s: req/vec actual %0b/%02h expected %0b/%02h",
                         phase, req, vec, m_req, m_vec);
            end
            if (ack) begin
                ack = 1'b0;
            end else if (req && auto_ack) begin
                if (!svc) begin
                    service(vec); svc = 1'b1;
                end else begin
                    ack = 1'b1; got.push_back(vec); svc = 1'b0;
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_got(input logic [7:0] v, input string tag);
        logic [7:0] a;
        checks++;
        a = (got.size() > 0) ? got.pop_front() : 8'hXX;
        if (a !== v) begin
            errors++;
            $display("FAIL %s: delivered %02h expected %02h", tag, a, v);
        end
    endtask

    task automatic expect_none(input string tag);
        checks++;
        if (got.size() != 0) begin
            errors++;
            $display("FAIL %s: delivered %02h expected none", tag, got[0]);
            got.delete();
        end
    endtask

    task automatic expect_req(input logic e, input string tag);
        checks++;
        if (req !== e) begin
            errors++;
            $display("FAIL %s: irq_req_o %0b expected %0b", tag, req, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (req !== 1'b0 || vec !== 8'h00) begin
            errors++;
            $display("FAIL R1: reset req/vec %0b/%02h expected 0/00", req, vec);
        end

        phase = "R10"; dma[2] = 1'b1; idle(10); expect_got(8'h50, "R10");

        phase = "R6"; dma[3] = 1'b1; dma[1] = 1'b1; idle(15);
        expect_got(8'h41, "R6"); expect_got(8'h42, "R6");

        phase = "R5"; cprio = 5'd8; dma[0] = 1'b1; idle(20);
        expect_none("R5 equal priority held back"); expect_req(1'b0, "R5");
        cprio = 5'd7; idle(10); expect_got(8'h40, "R5");
        cprio = 5'd0;

        phase = "R9"; dvec[7:0] = 8'h03; dma[0] = 1'b1; idle(15);
        expect_none("R9 reserved dma vector");
        dma[0] = 1'b0; dvec[7:0] = 8'h40; idle(2);

        phase = "R3"; pins = ~8'h05; idle(15); expect_none("R3 reserved encoded");
        pins = 8'hFF; idle(4);
        pins = ~8'h9A; idle(12); expect_got(8'h9A, "R3");

        phase = "R2"; ded = 1'b1; lvec[3*8 +: 8] = 8'h60; lvec[5*8 +: 8] = 8'h61;
        idle(4);
        pins[3] = 1'b0;
        idle(2); expect_req(1'b0, "R2 before sync");
        idle(1); expect_req(1'b1, "R2 after sync");
        idle(10); expect_got(8'h60, "R2");

        phase = "R4"; pins[3] = 1'b0; pins[5] = 1'b0; idle(20);
        expect_got(8'h60, "R4 level / R6 tie"); expect_got(8'h61, "R4 level / R6 tie");

        edge_cfg[6] = 1'b1; lvec[6*8 +: 8] = 8'h70; cprio = 5'd31;
        pins[6] = 1'b0; idle(2); pins[6] = 1'b1; idle(20);
        expect_none("R4 edge masked");
        cprio = 5'd0; idle(12);
        expect_got(8'h70, "R4 edge latched"); expect_none("R4 edge single delivery");

        phase = "R7"; auto_ack = 1'b0; dma[2] = 1'b1; idle(3);
        expect_req(1'b1, "R8 held");
        dma[3] = 1'b1; nmi_n = 1'b0; idle(2); nmi_n = 1'b1; idle(6);
        checks++;
        if (vec !== 8'h50) begin
            errors++;
            $display("FAIL R8: held vector %02h expected 50", vec);
        end
        auto_ack = 1'b1; idle(25);
        expect_got(8'h50, "R8"); expect_got(8'(NMI_V), "R7"); expect_got(8'h42, "R7");

        cprio = 5'd31; nmi_n = 1'b0; idle(2); nmi_n = 1'b1; idle(12);
        expect_got(8'(NMI_V), "R7 ignores priority"); cprio = 5'd0;

        phase = "R4 random dedicated";
        for (int i = 0; i < 8; i++) lvec[i*8 +: 8] = 8'($urandom_range(255, 8));
        edge_cfg = 8'($urandom);
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if ($urandom_range(7) == 0) pins[$urandom_range(7)] ^= 1'b1;
            if ($urandom_range(9) == 0) dma[$urandom_range(3)] = 1'b1;
            if ($urandom_range(40) == 0) cprio = 5'($urandom);
            if ($urandom_range(60) == 0) nmi_n = 1'b0;
            else if ($urandom_range(3) == 0) nmi_n = 1'b1;
            if ($urandom_range(300) == 0) edge_cfg = 8'($urandom);
        end
        pins = 8'hFF; dma = '0; nmi_n = 1'b1; idle(20);

        phase = "R3 random encoded"; ded = 1'b0; idle(6);
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            if ($urandom_range(11) == 0) pins = 8'($urandom);
            if ($urandom_range(15) == 0) dma[$urandom_range(3)] = 1'b1;
            if ($urandom_range(50) == 0) cprio = 5'($urandom_range(20));
        end
        idle(10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule